// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block connects a synchronous request/response port inside a chip to an external asynchronous static RAM organised as 16-bit words. A requester offers an access with a valid/ready handshake. Each access carries a word address, a read/write flag, write data and one enable bit per byte lane. The controller then sequences the active-low memory strobes: chip select, write strobe, output enable and one lane strobe per byte. It presents the address and handles the data pins as a split pad interface of output value, output enable and input value. Write cycles are controlled by the write strobe: data is captured by the memory when that strobe rises. Reads return the sampled word with a one-cycle response pulse.

Every phase lasts a whole number of clock cycles. The counts are derived when the block is elaborated, from the clock period and the memory's address access, output-enable access, write-pulse and cycle times, each rounded up. Between accesses the chip select is released, so the memory rests in standby with its pins at high impedance. The controller enables its data drivers only in a cycle whose previous cycle already had output enable released. When a write follows a read, it also inserts a turnaround cycle.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, chip select, write strobe, output enable and both lane strobes are high, the data drivers are off, the response pulse is low and ready is high.
- R2: An access is taken on a clock edge where request valid and ready are both high. Ready is low from the following cycle until that access has finished, and is high only when no access is in progress.
- R3: During a read, chip select and output enable are low, the write strobe is high, the address output equals the request address, and lane strobe i (bit 0 covers data bits 7:0, bit 1 covers bits 15:8) is low exactly when request enable bit i was set.
- R4: A read returns its word with the response pulse high for exactly one cycle, RD_CYC+1 cycles after the accepting edge. Returned lanes whose enable bit was clear read as zero.
- R5: During a write, chip select and the write strobe are low, output enable is high, the drivers are on with the request data, and address and lane strobes follow the request as in R3.
- R6: In the cycle after the write strobe rises, chip select stays low, the drivers stay on, and the address and data outputs are unchanged. Ready returns WR_CYC+2 cycles after the accepting edge.
- R7: When the previous access was a read, a write first spends one cycle with all strobes high and the drivers off. Ready then returns WR_CYC+3 cycles after acceptance.
- R8: The data drivers are never on while output enable is low, nor in a cycle that directly follows one with output enable low.
- R9: A write changes only the byte lanes whose enable bit is set. The other lanes of that word keep their previous contents.
- R10: Output enable stays low for exactly RD_CYC cycles per read, and the write strobe stays low for exactly WR_CYC cycles per write. RD_CYC is the larger of the rounded-up address and output-enable access times, and WR_CYC is the larger of the rounded-up write pulse and the rounded-up cycle time minus one. With the defaults (10 ns clock, 12 ns access, 6 ns output-enable access, 12 ns pulse and cycle) both are 2.
- R11: Whenever ready is high, chip select is high, which keeps the memory in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte-lane enables, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | DATA_W | Read word, unselected lanes zero |
| sram_addr | output | ADDR_W | Address to the memory |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_be_n | output | DATA_W/8 | Lane strobes, active low |
| sram_dq_o | output | DATA_W | Data pad output value |
| sram_dq_oe | output | 1 | Data pad driver enable |
| sram_dq_i | input | DATA_W | Data pad input value |

## Verification
A sequencer stuck in the wrong state shows up at the pins within one cycle. Ready may be high while chip select is low, the drivers may be on next to a low output enable, or a strobe may stay low longer than its count. A wrong wait count lengthens or shortens a strobe window and moves the response pulse by the same number of cycles. A model memory that returns junk until the access time has elapsed then turns a short read window into a wrong word. Lane or hold errors stay latent until the affected word is read back, so reads are kept close to the writes they depend on.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_TURN,
      SQ_READ,
      SQ_WRITE,
      SQ_HOLD
   } sq_state_e;

   typedef struct packed {
      logic ce_n;
      logic we_n;
      logic oe_n;
      logic drive;
      logic lanes_on;
   } bus_ctl_t;

   // whole clock cycles covering a time, rounded up
   function automatic int cycles_for(input int t_ps, input int clk_ps);
      return (t_ps + clk_ps - 1) / clk_ps;
   endfunction

   // pin pattern belonging to each sequencer state
   function automatic bus_ctl_t ctl_for(input sq_state_e s);
      bus_ctl_t c;
      c = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0, lanes_on: 1'b0};
      case (s)
         SQ_READ: begin
            c.ce_n = 1'b0;
            c.oe_n = 1'b0;
            c.lanes_on = 1'b1;
         end
         SQ_WRITE: begin
            c.ce_n = 1'b0;
            c.we_n = 1'b0;
            c.drive = 1'b1;
            c.lanes_on = 1'b1;
         end
         SQ_HOLD: begin
            c.ce_n = 1'b0;
            c.drive = 1'b1;
            c.lanes_on = 1'b1;
         end
         default: ;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/asram_wait.sv
module asram_wait #(
   parameter int MAXV  = 2,
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);

   if (CNT_W < 1) begin : g_bad_w
      $error("asram_wait: CNT_W must be at least 1");
   end

   if (MAXV <= 1) begin : g_single
      // every phase is one cycle long: no counter needed
      logic unused_wait;
      assign unused_wait = ^{clk, rst_n, load, load_val};
      assign last = 1'b1;
   end else begin : g_count
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (load) begin
            cnt_q <= load_val;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end

      assign last = (cnt_q == '0);
   end

endmodule

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int CNT_W  = 2,
   parameter int RD_CYC = 2,
   parameter int WR_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   output logic             req_ready,
   output logic             accept,
   output logic             cnt_load,
   output logic [CNT_W-1:0] cnt_val,
   input  logic             cnt_last,
   output bus_ctl_t         ctl,
   output logic             lanes_on_nxt,
   output logic             capture,
   output logic             rsp_valid
);

   sq_state_e st_q, st_nxt;
   bus_ctl_t  ctl_q, ctl_nxt;
   logic      last_rd_q;
   logic      rsp_q;

   assign req_ready = (st_q == SQ_IDLE);
   assign accept    = req_valid && req_ready;

   always_comb begin
      st_nxt = st_q;
      case (st_q)
         SQ_IDLE: begin
            if (accept) begin
               if (!req_write)     st_nxt = SQ_READ;
               else if (last_rd_q) st_nxt = SQ_TURN;
               else                st_nxt = SQ_WRITE;
            end
         end
         SQ_TURN:  st_nxt = SQ_WRITE;
         SQ_READ:  if (cnt_last) st_nxt = SQ_IDLE;
         SQ_WRITE: if (cnt_last) st_nxt = SQ_HOLD;
         SQ_HOLD:  st_nxt = SQ_IDLE;
         default:  st_nxt = SQ_IDLE;
      endcase
   end

   assign cnt_load = (st_nxt != st_q) && (st_nxt == SQ_READ || st_nxt == SQ_WRITE);
   assign cnt_val  = (st_nxt == SQ_READ) ? CNT_W'(RD_CYC - 1) : CNT_W'(WR_CYC - 1);
   assign capture  = (st_q == SQ_READ) && cnt_last;

   assign ctl_nxt      = ctl_for(st_nxt);
   assign lanes_on_nxt = ctl_nxt.lanes_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= SQ_IDLE;
         ctl_q     <= '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0, lanes_on: 1'b0};
         last_rd_q <= 1'b0;
         rsp_q     <= 1'b0;
      end else begin
         st_q  <= st_nxt;
         ctl_q <= ctl_nxt;
         rsp_q <= capture;
         if (st_q == SQ_READ)       last_rd_q <= 1'b1;
         else if (st_q == SQ_WRITE) last_rd_q <= 1'b0;
      end
   end

   assign ctl       = ctl_q;
   assign rsp_valid = rsp_q;

   // R11
   idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> ctl_q.ce_n);

   // R2
   busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);

   // R4
   rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_q |=> !rsp_q);

   // R3
   oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q.oe_n |-> (ctl_q.we_n && !ctl_q.ce_n));

   // R8
   drive_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q.drive |-> (ctl_q.oe_n && $past(ctl_q.oe_n)));

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   input  logic              lanes_on_nxt,
   input  logic              capture,
   input  logic [DATA_W-1:0] dq_i,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] dq_o,
   output logic [LANES-1:0]  be_n,
   output logic [DATA_W-1:0] rdata
);

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  be_q, be_n_q, be_use;

   assign be_use = accept ? req_be : be_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         be_q    <= '0;
         be_n_q  <= '1;
      end else begin
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
         end
         be_n_q <= lanes_on_nxt ? ~be_use : '1;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
         end else if (capture) begin
            byte_q <= be_q[l] ? dq_i[l*8 +: 8] : 8'h00;
         end
      end
      assign rdata[l*8 +: 8] = byte_q;
   end

   assign addr = addr_q;
   assign dq_o = wdata_q;
   assign be_n = be_n_q;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 16,
   parameter int CLK_PS  = 10000,
   parameter int T_AA_PS = 12000,
   parameter int T_OE_PS = 6000,
   parameter int T_WP_PS = 12000,
   parameter int T_WC_PS = 12000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_write,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic [DATA_W/8-1:0]   req_be,
   output logic                  rsp_valid,
   output logic [DATA_W-1:0]     rsp_rdata,
   output logic [ADDR_W-1:0]     sram_addr,
   output logic                  sram_ce_n,
   output logic                  sram_we_n,
   output logic                  sram_oe_n,
   output logic [DATA_W/8-1:0]   sram_be_n,
   output logic [DATA_W-1:0]     sram_dq_o,
   output logic                  sram_dq_oe,
   input  logic [DATA_W-1:0]     sram_dq_i
);

   localparam int LANES   = DATA_W / 8;
   localparam int AA_CYC  = cycles_for(T_AA_PS, CLK_PS);
   localparam int OE_CYC  = cycles_for(T_OE_PS, CLK_PS);
   localparam int WP_CYC  = cycles_for(T_WP_PS, CLK_PS);
   localparam int WC_CYC  = cycles_for(T_WC_PS, CLK_PS);
   localparam int RD_RAW  = (AA_CYC > OE_CYC) ? AA_CYC : OE_CYC;
   localparam int RD_CYC  = (RD_RAW < 1) ? 1 : RD_RAW;
   localparam int WR_RAW  = (WP_CYC > WC_CYC - 1) ? WP_CYC : WC_CYC - 1;
   localparam int WR_CYC  = (WR_RAW < 1) ? 1 : WR_RAW;
   localparam int CNT_MAX = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data
      $error("asram_ctrl: DATA_W must be a positive multiple of 8");
   end
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
      $error("asram_ctrl: ADDR_W must lie in 1..32");
   end
   if (CLK_PS < 1) begin : g_bad_clk
      $error("asram_ctrl: CLK_PS must be positive");
   end

   logic             accept, cnt_load, cnt_last, lanes_on_nxt, capture;
   logic [CNT_W-1:0] cnt_val;
   bus_ctl_t         ctl;

   asram_seq #(
      .CNT_W  (CNT_W),
      .RD_CYC (RD_CYC),
      .WR_CYC (WR_CYC)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_write    (req_write),
      .req_ready    (req_ready),
      .accept       (accept),
      .cnt_load     (cnt_load),
      .cnt_val      (cnt_val),
      .cnt_last     (cnt_last),
      .ctl          (ctl),
      .lanes_on_nxt (lanes_on_nxt),
      .capture      (capture),
      .rsp_valid    (rsp_valid)
   );

   asram_wait #(
      .MAXV  (CNT_MAX),
      .CNT_W (CNT_W)
   ) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .last     (cnt_last)
   );

   asram_datapath #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LANES  (LANES)
   ) u_dp (
      .clk          (clk),
      .rst_n        (rst_n),
      .accept       (accept),
      .req_addr     (req_addr),
      .req_wdata    (req_wdata),
      .req_be       (req_be),
      .lanes_on_nxt (lanes_on_nxt),
      .capture      (capture),
      .dq_i         (sram_dq_i),
      .addr         (sram_addr),
      .dq_o         (sram_dq_o),
      .be_n         (sram_be_n),
      .rdata        (rsp_rdata)
   );

   assign sram_ce_n  = ctl.ce_n;
   assign sram_we_n  = ctl.we_n;
   assign sram_oe_n  = ctl.oe_n;
   assign sram_dq_oe = ctl.drive;

   // R6
   write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> (sram_dq_oe && !sram_ce_n && $stable(sram_addr) && $stable(sram_dq_o)));

   // R5
   write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> (sram_dq_oe && sram_oe_n && !sram_ce_n));

endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

   localparam int ACC = 2;   // ceil(12 ns / 10 ns)
   localparam int WRC = 2;   // ceil(12 ns / 10 ns)

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [15:0] req_addr = '0, req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        req_ready, rsp_valid, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
   logic [15:0] rsp_rdata, sram_addr, sram_dq_o;
   logic [1:0]  sram_be_n;
   logic [15:0] sram_dq_i = 16'h5AA5;

   asram_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
      .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
      .sram_be_n(sram_be_n), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
      .sram_dq_i(sram_dq_i)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;

   logic [15:0] bus_mem [logic [15:0]];
   logic [15:0] ref_mem [logic [15:0]];
   logic [15:0] exp_q [$];

   logic [15:0] cur_addr, cur_wdata;
   logic [1:0]  cur_be;
   logic        cur_turn, last_rd = 1'b0;

   function automatic logic [15:0] init_word(input logic [15:0] a);
      return (a * 16'd40503) ^ 16'h6C1B;
   endfunction

   function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                         input logic [1:0] be);
      logic [15:0] r;
      r = old;
      if (be[0]) r[7:0]  = nw[7:0];
      if (be[1]) r[15:8] = nw[15:8];
      return r;
   endfunction

   function automatic logic [15:0] lane_mask(input logic [15:0] w, input logic [1:0] be);
      return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- pin monitor and memory model ----------------
   int          cyc = 0, acc_cyc = 0, oe_run = 0, we_run = 0, rd_age = 0;
   int          turn_cyc = -1;
   bit          wr_pend = 0, rd_pend = 0, acc_turn = 0, prev_rd_en = 0;
   logic        prev_oe_n = 1'b1, prev_we_n = 1'b1;
   logic [15:0] prev_addr = '0, prev_dq = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         logic [15:0] word, exp, got;
         cyc++;
         // completion of outstanding accesses
         if (wr_pend && req_ready) begin
            // R6 / R7 write latency
            chk(cyc - acc_cyc == WRC + 2 + (acc_turn ? 1 : 0), acc_turn ? "R7" : "R6",
                "write ready latency", cyc - acc_cyc, WRC + 2 + (acc_turn ? 1 : 0));
            wr_pend = 0;
         end
         if (rsp_valid) begin
            // R4 read response timing and data
            chk(rd_pend && (cyc - acc_cyc == ACC + 1), "R4", "response cycle", cyc - acc_cyc, ACC + 1);
            exp = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hxxxx;
            chk(rsp_rdata == exp, "R4", "read word", rsp_rdata, exp);
            rd_pend = 0;
         end
         if (req_valid && req_ready) begin
            acc_cyc  = cyc;
            acc_turn = cur_turn;
            if (req_write) wr_pend = 1; else rd_pend = 1;
            if (req_write && cur_turn) turn_cyc = cyc + 1;
         end
         // R11 standby while idle
         if (req_ready) chk(sram_ce_n, "R11", "chip select while idle", sram_ce_n, 1);
         // R7 turnaround cycle
         if (cyc == turn_cyc)
            chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R7", "turnaround pins",
                {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b1110);
         // R8 no drive next to output enable
         if (sram_dq_oe)
            chk(sram_oe_n && prev_oe_n, "R8", "drive with output enable", {prev_oe_n, sram_oe_n}, 2'b11);
         // R3 read pins
         if (!sram_oe_n)
            chk(!sram_ce_n && sram_we_n && sram_be_n == ~cur_be && sram_addr == cur_addr, "R3",
                "read pins", {sram_ce_n, sram_we_n, sram_be_n, sram_addr}, {1'b0, 1'b1, ~cur_be, cur_addr});
         // R5 write pins
         if (!sram_we_n)
            chk(!sram_ce_n && sram_oe_n && sram_dq_oe && sram_dq_o == cur_wdata &&
                sram_addr == cur_addr && sram_be_n == ~cur_be, "R5", "write pins",
                {sram_dq_o, sram_addr}, {cur_wdata, cur_addr});
         // R10 strobe widths
         if (!sram_oe_n) oe_run++;
         else if (!prev_oe_n) begin
            chk(oe_run == ACC, "R10", "output enable width", oe_run, ACC);
            oe_run = 0;
         end
         if (!sram_we_n) we_run++;
         else if (!prev_we_n) begin
            chk(we_run == WRC, "R10", "write strobe width", we_run, WRC);
            we_run = 0;
            // R6 hold after write strobe rises
            chk(sram_dq_oe && !sram_ce_n && sram_addr == prev_addr && sram_dq_o == prev_dq, "R6",
                "hold after strobe", {sram_dq_o, sram_addr}, {prev_dq, prev_addr});
            if (!sram_ce_n) begin
               word = bus_mem.exists(sram_addr) ? bus_mem[sram_addr] : init_word(sram_addr);
               bus_mem[sram_addr] = merge(word, sram_dq_o, ~sram_be_n);
            end
         end
         // memory read path: junk until the access time is met
         if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
            rd_age = (prev_rd_en && sram_addr == prev_addr) ? rd_age + 1 : 1;
            word = bus_mem.exists(sram_addr) ? bus_mem[sram_addr] : init_word(sram_addr);
            got[7:0]  = (!sram_be_n[0] && rd_age >= ACC) ? word[7:0]  : 8'hC3;
            got[15:8] = (!sram_be_n[1] && rd_age >= ACC) ? word[15:8] : 8'h3C;
            sram_dq_i  = got;
            prev_rd_en = 1;
         end else begin
            rd_age     = 0;
            prev_rd_en = 0;
            sram_dq_i  = 16'h5AA5;
         end
         prev_oe_n = sram_oe_n;
         prev_we_n = sram_we_n;
         prev_addr = sram_addr;
         prev_dq   = sram_dq_o;
      end
   end

   // ---------------- stimulus ----------------
   task automatic issue(input bit w, input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
      logic [15:0] old;
      forever begin
         @(posedge clk); #1;
         if (req_ready) break;
      end
      cur_addr  = a;
      cur_wdata = d;
      cur_be    = be;
      cur_turn  = last_rd;
      last_rd   = !w;
      old = ref_mem.exists(a) ? ref_mem[a] : init_word(a);
      if (w) ref_mem[a] = merge(old, d, be);   // R9 reference
      else   exp_q.push_back(lane_mask(old, be));
      req_valid = 1'b1;
      req_write = w;
      req_addr  = a;
      req_wdata = d;
      req_be    = be;
      @(posedge clk); #1;
      req_valid = 1'b0;
      req_wdata = 16'hFFFF;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog run did not complete");
      finish_run();
   end

   initial begin
      void'($urandom(32'd24601));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(sram_ce_n && sram_we_n && sram_oe_n && sram_be_n == 2'b11 && !sram_dq_oe && !rsp_valid,
          "R1", "pins in reset", {sram_ce_n, sram_we_n, sram_oe_n, sram_be_n, sram_dq_oe, rsp_valid},
          7'b1111100);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && sram_ce_n && !sram_dq_oe, "R1", "idle after reset",
          {req_ready, sram_ce_n, sram_dq_oe}, 3'b110);

      // directed corners
      issue(1, 16'h0000, 16'hA1B2, 2'b11);    // R5 full write
      issue(0, 16'h0000, 16'h0000, 2'b11);    // R4 read back
      issue(1, 16'h0000, 16'h7788, 2'b01);    // R7 write after read, low lane only
      issue(0, 16'h0000, 16'h0000, 2'b11);    // R9 upper lane kept
      issue(1, 16'hFFFF, 16'h1357, 2'b10);    // R9 upper lane only at top address
      issue(0, 16'hFFFF, 16'h0000, 2'b01);    // R4 upper lane masked to zero
      issue(0, 16'hFFFF, 16'h0000, 2'b11);    // back-to-back reads
      issue(1, 16'h0042, 16'hCAFE, 2'b11);
      issue(1, 16'h0042, 16'hBEEF, 2'b00);    // R9 no lane selected
      issue(0, 16'h0042, 16'h0000, 2'b11);
      issue(0, 16'h0042, 16'h0000, 2'b00);

      for (int i = 0; i < 300; i++) begin
         logic [15:0] a;
         a = ($urandom % 4 == 0) ? 16'($urandom) : {12'h000, 4'($urandom)};
         issue(1'($urandom), a, 16'($urandom), 2'($urandom));
         repeat ($urandom % 3) @(posedge clk);
      end

      repeat (ACC + WRC + 6) @(posedge clk);
      @(negedge clk);
      chk(exp_q.size() == 0 && req_ready, "R4", "all reads answered", exp_q.size(), 0);
      finish_run();
   end

endmodule